// File: doc/BRIEF.md
# Paged Register SPI Master

This block drives register reads and writes into an external device whose register space is split into pages. The device is reached over a four-wire serial link with an active-low select. A local requester offers one access at a time on a valid/ready request port. Each request carries a direction, a page number, a register address, a length code and up to four bytes of write data. The block answers with a one-cycle `done` pulse together with `err` and `rdata`.

The block keeps the last page it selected. When a request targets a different page, or no page has been selected since reset, the block first sends a page-select frame. It then sends the access frame, each frame framed by its own select window. Writes send a command byte, the register address and the data bytes, least significant byte first. Reads use a fast-read command and then poll. Bytes are clocked in and thrown away until one has bit 0 set. That byte is the acknowledge, and the data bytes follow it.

Request back-pressure: `req_ready` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable while `req_valid` is high and `req_ready` is low. The response side has no back-pressure. `rdata` and `err` stay stable from the `done` pulse until the next request is accepted.

Top module: `spi_pagereg_master`

## Requirements
- R1: After reset and whenever `ss_n` is high, `sck` and `mosi` are low and `ss_n` idles high. `sck` is high only while `ss_n` is low. After reset `busy` and `done` are low and `req_ready` is high.
- R2: A write frame is the byte 0x61, then the register address, then the data bytes taken from `req_wdata` bits [7:0] upward, least significant byte first.
- R3: A read frame starts with the byte 0x10 and then the register address. `mosi` is low for all later bytes. Data bytes fill `rdata` from bits [7:0] upward, and the bytes beyond the length read as zero.
- R4: Before an access whose page differs from the cached page, and before the first access after reset, a separate frame is sent: 0x61, 0xFF, then the page number. The page number then becomes the cached page.
- R5: An access to the cached page sends no page-select frame.
- R6: Each byte goes out MSB first. `mosi` changes only while `sck` is low, and the device samples it on the rising edge of `sck`.
- R7: During a read, incoming bytes with bit 0 clear are discarded. The first byte with bit 0 set is the acknowledge and is not data. Exactly the requested number of data bytes follow it.
- R8: If 100 consecutive polled bytes (`MAX_TRIES`) carry no acknowledge, the frame ends and `done` pulses with `err` = 1. An acknowledge on the 100th attempt still completes the read with `err` = 0, and later accesses work normally.
- R9: `sck` high time is exactly HALF = `CLK_MHZ`*`HALF_US` cycles. Within a byte, `sck` stays low for HALF + SETUP cycles between rising edges, where SETUP = `CLK_MHZ`*`SETUP_US`. At least SEL + HALF + SETUP cycles pass from the fall of `ss_n` to the first rising edge, where SEL = `CLK_MHZ`*`SEL_US`.
- R10: `busy` is high from the cycle after a request is accepted through the `done` cycle, and low in the cycle after `done`. `req_ready` equals not `busy`, and `done` is a single-cycle pulse.
- R11: The length code `req_len` gives the number of data bytes: 0 → 1, 1 → 2, 2 → 4, and 3 → 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 8 | Target page |
| req_addr | input | 8 | Register address within the page |
| req_len | input | 2 | Length code (R11) |
| req_wdata | input | 32 | Write data, least significant byte sent first |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Acknowledge timeout on the last access |
| rdata | output | 32 | Read data, zero-extended |
| ss_n | output | 1 | Select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
A stale or wrongly updated page cache shows as a page-select frame that is missing or extra, within the frames of the next request whose page it touches. A miscounted byte or poll index shows at the first `done` of that access as a frame of the wrong length, a shifted `rdata` or a wrong `err`. A broken bit phase shows within one `sck` period, as a high pulse of the wrong width or a `mosi` edge while `sck` is high.

// File: rtl/spi_pagereg_pkg.sv
package spi_pagereg_pkg;

  localparam logic [7:0] CMD_WRITE = 8'h61;
  localparam logic [7:0] CMD_FREAD = 8'h10;
  localparam logic [7:0] PAGE_SEL_REG = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_XFER, ST_HOLD, ST_GAP, ST_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    BY_CMD, BY_ADDR, BY_PAGE, BY_WDATA, BY_POLL, BY_RDATA
  } byte_role_t;

  typedef enum logic [1:0] {
    SH_IDLE, SH_LOWA, SH_LOWB, SH_HIGH
  } shift_state_t;

  // index of the last data byte for a length code
  function automatic logic [1:0] last_index(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] i);
    return w[{i, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_pagereg_pkg::*;
#(
  parameter int HALF_CYC  = 250,
  parameter int SETUP_CYC = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int MAXC = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HALF_LD  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);

  shift_state_t st;
  logic [CW-1:0] cnt;
  logic [2:0] bitn;
  logic [7:0] txsh;
  logic [7:0] rxsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SH_IDLE;
      cnt  <= '0;
      bitn <= '0;
      txsh <= '0;
      rxsh <= '0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (start) begin
            txsh <= tx_byte;
            bitn <= '0;
            cnt  <= HALF_LD;
            st   <= SH_LOWA;
          end
        end
        SH_LOWA: begin
          if (cnt == '0) begin
            mosi <= txsh[7];
            cnt  <= SETUP_LD;
            st   <= SH_LOWB;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SH_LOWB: begin
          if (cnt == '0) begin
            sck  <= 1'b1;
            rxsh <= {rxsh[6:0], miso};
            cnt  <= HALF_LD;
            st   <= SH_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            sck  <= 1'b0;
            txsh <= {txsh[6:0], 1'b0};
            if (bitn == 3'd7) begin
              done <= 1'b1;
              mosi <= 1'b0;
              st   <= SH_IDLE;
            end else begin
              bitn <= bitn + 1'b1;
              cnt  <= HALF_LD;
              st   <= SH_LOWA;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign rx_byte = rxsh;

  // R6
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> (mosi == $past(mosi)));

endmodule

// File: rtl/pagereg_seq.sv
module pagereg_seq
  import spi_pagereg_pkg::*;
#(
  parameter int MAX_TRIES = 100,
  parameter int SEL_CYC   = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        req_write,
  input  logic [7:0]  req_page,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        bs_start,
  output logic [7:0]  bs_tx,
  input  logic        bs_done,
  input  logic [7:0]  bs_rx,
  output logic        ss_n,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam int SW = $clog2(SEL_CYC + 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES);
  localparam logic [SW-1:0] SEL_LD   = SW'(SEL_CYC - 1);

  seq_state_t st;
  byte_role_t role;
  logic          pg_txn;
  logic          cache_ok;
  logic [7:0]    cache_pg;
  logic          wr_q;
  logic [7:0]    page_q;
  logic [7:0]    addr_q;
  logic [1:0]    last_q;
  logic [31:0]   wdata_q;
  logic [1:0]    idx;
  logic [TW-1:0] tries;
  logic [SW-1:0] cnt;
  logic          ss_q;
  logic          err_q;
  logic [31:0]   rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      role     <= BY_CMD;
      pg_txn   <= 1'b0;
      cache_ok <= 1'b0;
      cache_pg <= '0;
      wr_q     <= 1'b0;
      page_q   <= '0;
      addr_q   <= '0;
      last_q   <= '0;
      wdata_q  <= '0;
      idx      <= '0;
      tries    <= '0;
      cnt      <= '0;
      ss_q     <= 1'b1;
      bs_start <= 1'b0;
      bs_tx    <= '0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      bs_start <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_fire) begin
            wr_q    <= req_write;
            page_q  <= req_page;
            addr_q  <= req_addr;
            last_q  <= last_index(req_len);
            wdata_q <= req_wdata;
            pg_txn  <= !(cache_ok && (cache_pg == req_page));
            err_q   <= 1'b0;
            rdata_q <= '0;
            ss_q    <= 1'b0;
            cnt     <= SEL_LD;
            st      <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (cnt == '0) begin
            bs_start <= 1'b1;
            bs_tx    <= (pg_txn || wr_q) ? CMD_WRITE : CMD_FREAD;
            role     <= BY_CMD;
            st       <= ST_XFER;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_XFER: begin
          if (bs_done) begin
            case (role)
              BY_CMD: begin
                bs_start <= 1'b1;
                bs_tx    <= pg_txn ? PAGE_SEL_REG : addr_q;
                role     <= BY_ADDR;
              end
              BY_ADDR: begin
                bs_start <= 1'b1;
                if (pg_txn) begin
                  bs_tx <= page_q;
                  role  <= BY_PAGE;
                end else if (wr_q) begin
                  bs_tx <= wdata_q[7:0];
                  idx   <= '0;
                  role  <= BY_WDATA;
                end else begin
                  bs_tx <= '0;
                  tries <= TW'(1);
                  role  <= BY_POLL;
                end
              end
              BY_PAGE: begin
                cache_pg <= page_q;
                cache_ok <= 1'b1;
                cnt      <= SEL_LD;
                st       <= ST_HOLD;
              end
              BY_WDATA: begin
                if (idx == last_q) begin
                  cnt <= SEL_LD;
                  st  <= ST_HOLD;
                end else begin
                  idx      <= idx + 2'd1;
                  bs_tx    <= pick_byte(wdata_q, idx + 2'd1);
                  bs_start <= 1'b1;
                end
              end
              BY_POLL: begin
                if (bs_rx[0]) begin
                  idx      <= '0;
                  bs_tx    <= '0;
                  role     <= BY_RDATA;
                  bs_start <= 1'b1;
                end else if (tries == TRY_LAST) begin
                  err_q <= 1'b1;
                  cnt   <= SEL_LD;
                  st    <= ST_HOLD;
                end else begin
                  tries    <= tries + TW'(1);
                  bs_tx    <= '0;
                  bs_start <= 1'b1;
                end
              end
              default: begin
                rdata_q[{idx, 3'b000} +: 8] <= bs_rx;
                if (idx == last_q) begin
                  cnt <= SEL_LD;
                  st  <= ST_HOLD;
                end else begin
                  idx      <= idx + 2'd1;
                  bs_tx    <= '0;
                  bs_start <= 1'b1;
                end
              end
            endcase
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            ss_q <= 1'b1;
            cnt  <= SEL_LD;
            st   <= ST_GAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            if (pg_txn) begin
              pg_txn <= 1'b0;
              ss_q   <= 1'b0;
              cnt    <= SEL_LD;
              st     <= ST_SEL;
            end else begin
              st <= ST_DONE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ss_n  = ss_q;
  assign busy  = (st != ST_IDLE);
  assign done  = (st == ST_DONE);
  assign err   = err_q;
  assign rdata = rdata_q;

  // R8
  poll_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (role == BY_POLL) |-> (tries <= TRY_LAST));

  // R4
  page_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEL && !cache_ok) |-> pg_txn);

endmodule

// File: rtl/spi_pagereg_master.sv
module spi_pagereg_master
  import spi_pagereg_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int HALF_US   = 2,
  parameter int SETUP_US  = 1,
  parameter int SEL_US    = 1,
  parameter int MAX_TRIES = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_page,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  output logic        ss_n,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  localparam int HALF_CYC  = CLK_MHZ * HALF_US;
  localparam int SETUP_CYC = CLK_MHZ * SETUP_US;
  localparam int SEL_CYC   = CLK_MHZ * SEL_US;

  logic       req_fire;
  logic       bs_start;
  logic [7:0] bs_tx;
  logic       bs_done;
  logic [7:0] bs_rx;

  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;

  pagereg_seq #(
    .MAX_TRIES(MAX_TRIES),
    .SEL_CYC  (SEL_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .req_write(req_write),
    .req_page (req_page),
    .req_addr (req_addr),
    .req_len  (req_len),
    .req_wdata(req_wdata),
    .bs_start (bs_start),
    .bs_tx    (bs_tx),
    .bs_done  (bs_done),
    .bs_rx    (bs_rx),
    .ss_n     (ss_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rdata    (rdata)
  );

  spi_byte_shifter #(
    .HALF_CYC (HALF_CYC),
    .SETUP_CYC(SETUP_CYC)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (bs_start),
    .tx_byte(bs_tx),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .done   (bs_done),
    .rx_byte(bs_rx)
  );

  // R1
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !ss_n);

  // R1
  idle_mosi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !mosi);

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && req_ready && !done));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

endmodule

// File: tb/spi_pagereg_master_test.sv
module spi_pagereg_master_test;
  localparam int HALF = 2;
  localparam int SETUP = 1;
  localparam int SEL = 1;
  localparam int TRIES = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [7:0] req_page = '0;
  logic [7:0] req_addr = '0;
  logic [1:0] req_len = '0;
  logic [31:0] req_wdata = '0;
  logic busy, done, err;
  logic [31:0] rdata;
  logic ss_n, sck, mosi;
  logic miso;

  always #4 clk = ~clk;

  spi_pagereg_master #(
    .CLK_MHZ(1), .HALF_US(HALF), .SETUP_US(SETUP), .SEL_US(SEL), .MAX_TRIES(TRIES)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .ss_n(ss_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem [0:3][0:15];
  logic [7:0] fr [0:127];
  int fbits = 0;
  logic [7:0] cur = '0;
  int spage = 0;
  int page_frames = 0, wr_frames = 0, rd_frames = 0, bad_frames = 0, last_nfb = 0;
  int ack_dly = 0;
  bit no_ack = 0;

  always @(posedge sck or posedge ss_n) begin
    if (ss_n) begin
      if (fbits != 0) begin
        int nfb;
        nfb = fbits / 8;
        if (fbits % 8 != 0) bad_frames++;
        else if (nfb == 3 && fr[0] == 8'h61 && fr[1] == 8'hFF) begin
          spage = int'(fr[2][1:0]);
          page_frames++;
        end else if (nfb >= 3 && fr[0] == 8'h61) begin
          for (int k = 2; k < nfb; k++) mem[spage][(int'(fr[1]) + k - 2) & 15] = fr[k];
          wr_frames++;
        end else if (nfb >= 2 && fr[0] == 8'h10) rd_frames++;
        else bad_frames++;
        last_nfb = nfb;
      end
      fbits = 0;
      cur = '0;
    end else begin
      cur = {cur[6:0], mosi};
      fbits++;
      if (fbits % 8 == 0 && fbits / 8 <= 128) fr[fbits/8 - 1] = cur;
    end
  end

  logic [7:0] resp;
  int rj;
  always_comb begin
    rj = fbits / 8;
    if (rj < 2) resp = 8'h00;
    else if (no_ack || rj < 2 + ack_dly) resp = 8'hFE;
    else if (rj == 2 + ack_dly) resp = 8'h01;
    else resp = mem[spage][(int'(fr[1]) + rj - 3 - ack_dly) & 15];
    miso = resp[7 - (fbits % 8)];
  end

  // ---------------- line timing monitor ----------------
  logic p_sck = 0, p_ss = 1, p_mosi = 0;
  int hi_len = 0, lo_len = 0;
  bit first_rise = 0;
  int tim_err = 0, mosi_err = 0, idle_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ss_n && (sck || mosi)) idle_err++;
      if (sck && p_sck && mosi != p_mosi) mosi_err++;
      if (!ss_n && p_ss) begin lo_len = 0; first_rise = 1; end
      if (sck && !p_sck) begin
        if (first_rise) begin
          if (lo_len < SEL + HALF + SETUP) tim_err++;
        end else if (lo_len < HALF + SETUP) tim_err++;
        first_rise = 0;
        hi_len = 0;
      end
      if (!sck && p_sck) begin
        if (hi_len != HALF) tim_err++;
        lo_len = 0;
      end
      if (sck) hi_len++; else if (!ss_n) lo_len++;
      p_sck = sck; p_ss = ss_n; p_mosi = mosi;
    end
  end

  // ---------------- requester ----------------
  int exp_pg = -1;
  int exp_pf = 0;

  function automatic int nbytes(input logic [1:0] lc);
    return (lc == 2'd0) ? 1 : (lc == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] lmask(input logic [1:0] lc);
    return (lc == 2'd0) ? 32'hFF : (lc == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic run_txn(input bit wr, input int pg, input int ad, input logic [1:0] lc,
                         input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_page = 8'(pg); req_addr = 8'(ad);
    req_len = lc; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
    while (!done) @(negedge clk);
    rd = rdata; er = err;
    @(negedge clk);
    chk(!busy && req_ready && !done, "R10 release after done", {busy, req_ready, done}, 32'b010);
    if (pg != exp_pg) begin exp_pf++; exp_pg = pg; end
    chk(page_frames == exp_pf, (exp_pg == pg && page_frames == exp_pf) ? "R4/R5 page frames" : "R4/R5 page frames",
        32'(page_frames), 32'(exp_pf));
  endtask

  task automatic do_write(input int pg, input int ad, input logic [1:0] lc, input logic [31:0] wd);
    logic [31:0] rd; logic er; int nb; bit ok;
    run_txn(1'b1, pg, ad, lc, wd, rd, er);
    nb = nbytes(lc);
    chk(er == 1'b0, "R2 write err", 32'(er), 32'd0);
    chk(last_nfb == 2 + nb, "R2 R11 write frame length", 32'(last_nfb), 32'(2 + nb));
    ok = (fr[0] == 8'h61) && (fr[1] == 8'(ad));
    for (int k = 0; k < nb; k++) if (fr[2+k] != wd[8*k +: 8]) ok = 0;
    chk(ok, "R2 R6 write frame bytes", {fr[0], fr[1], fr[2], fr[3]}, {8'h61, 8'(ad), wd[7:0], wd[15:8]});
  endtask

  task automatic do_read(input int pg, input int ad, input logic [1:0] lc, input logic [31:0] exp);
    logic [31:0] rd; logic er; int nb;
    run_txn(1'b0, pg, ad, lc, 32'h0, rd, er);
    nb = nbytes(lc);
    chk(er == 1'b0, "R7 read err", 32'(er), 32'd0);
    chk(rd == exp, "R3 R7 R11 read data", rd, exp);
    chk(fr[0] == 8'h10 && fr[1] == 8'(ad), "R3 read header", {fr[0], fr[1]}, {8'h10, 8'(ad)});
    chk(last_nfb == 2 + ack_dly + 1 + nb, "R7 read frame length", 32'(last_nfb), 32'(3 + ack_dly + nb));
  endtask

  initial begin
    #1_600_000;
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic er; logic [31:0] wd;
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 16; a++) mem[p][a] = 8'((p * 16 + a) ^ 8'h5A);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ss_n && !sck && !mosi, "R1 idle lines", {ss_n, sck, mosi}, 32'b100);
    chk(!busy && !done && req_ready, "R1 idle handshake", {busy, done, req_ready}, 32'b001);

    // R4 first access after reset always selects the page
    do_write(1, 4, 2'd1, 32'h0000_BEEF);
    chk(page_frames == 1, "R4 first access page frame", 32'(page_frames), 32'd1);
    // R5 same page again
    do_write(1, 6, 2'd0, 32'h0000_0077);
    chk(page_frames == 1, "R5 no page frame on same page", 32'(page_frames), 32'd1);

    // sweep of pages, addresses and length codes
    for (int p = 0; p < 3; p++)
      for (int ai = 0; ai < 3; ai++)
        for (int lc = 0; lc < 4; lc++) begin
          int a;
          a = ai * 6;
          wd = (32'h0102_0304 * (p + 1)) ^ (32'(a) << 8) ^ (32'h1111_1111 * lc);
          do_write(p, a, 2'(lc), wd);
          ack_dly = (a + lc) % 4;
          do_read(p, a, 2'(lc), wd & lmask(2'(lc)));
        end

    // alternating pages: a page frame every access (R4)
    ack_dly = 0;
    for (int i = 0; i < 4; i++)
      do_read(i % 2, 0, 2'd0, {24'h0, mem[i % 2][0]});

    // short reads of a wide value: R3 zero fill, R11 code 3 is four bytes
    do_write(2, 8, 2'd3, 32'hA1B2_C3D4);
    do_read(2, 8, 2'd0, 32'h0000_00D4);
    do_read(2, 8, 2'd1, 32'h0000_C3D4);
    do_read(2, 8, 2'd2, 32'hA1B2_C3D4);

    // R8 acknowledge on the last allowed attempt
    ack_dly = TRIES - 1;
    do_read(2, 8, 2'd1, 32'h0000_C3D4);

    // R8 acknowledge one attempt too late
    ack_dly = TRIES;
    run_txn(1'b0, 2, 8, 2'd0, 32'h0, rd, er);
    chk(er == 1'b1, "R8 late ack error", 32'(er), 32'd1);
    chk(last_nfb == 2 + TRIES, "R8 late ack frame length", 32'(last_nfb), 32'(2 + TRIES));

    // R8 no acknowledge at all
    no_ack = 1;
    run_txn(1'b0, 2, 8, 2'd2, 32'h0, rd, er);
    chk(er == 1'b1, "R8 no ack error", 32'(er), 32'd1);
    chk(last_nfb == 2 + TRIES, "R8 no ack frame length", 32'(last_nfb), 32'(2 + TRIES));
    no_ack = 0;

    // R8 recovery, page still cached (R5)
    ack_dly = 1;
    do_read(2, 8, 2'd2, 32'hA1B2_C3D4);

    repeat (4) @(negedge clk);
    chk(idle_err == 0, "R1 lines idle outside frames", 32'(idle_err), 32'd0);
    chk(mosi_err == 0, "R6 mosi moves only with sck low", 32'(mosi_err), 32'd0);
    chk(tim_err == 0, "R9 sck phase widths", 32'(tim_err), 32'd0);
    chk(bad_frames == 0, "R2 R3 well formed frames", 32'(bad_frames), 32'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule